// File: doc/BRIEF.md
# Scrambled Bank-Controller Write Front-End

This block sits on the CPU write path in front of a standard scanline-interrupt bank-switching core. Each CPU write in the upper part of the address space is classified once and then handed to the core as a single-cycle command. The command carries a 2-bit register page and an odd/even select, which together name one of the core's native registers, plus the data byte. The core therefore needs no address decoder of its own. Writes to the work-RAM window are passed through on a separate strobe with the window offset.

The register map seen by the CPU is deliberately shuffled relative to the core. Some registers are reached at other addresses. The low index of a bank-select write is permuted through a fixed table. A bank-data write is accepted only once after each bank-select write. The block also holds an 8-bit outer register, loaded from its own window, whose value is output for use by outer banking logic elsewhere.

Commands leave the block one clock after the CPU write that caused them. The outer register and the one-shot flag update on that same edge.

Top module: `scr_map_frontend`

## Requirements
- R1: A write with address bits 15..12 equal to 5 loads all 8 data bits into `outer_q`, which is visible one cycle later. It raises neither `core_we` nor `wram_we`. `outer_q` changes on no other write.
- R2: A write in 0x6000..0x7FFF raises `wram_we` for one cycle, with `wram_off` = address bits 12..0 and `out_data` = write data. `core_we` stays low.
- R3: From 0x8000 upward only address bits 15, 14, 13 and 0 select the function. Any address with the same values of those bits behaves identically; for example, 0x9FFF acts as 0x8001.
- R4: A write decoding to 0x8001 issues page 1, even (mirroring) with the data unchanged. A write decoding to 0xA001 issues page 2, even (IRQ latch).
- R5: A write decoding to 0xA000 issues page 0, even (bank select). The data keeps bits 7..6, clears bits 5..3, and replaces bits 2..0 through the map 0→0, 1→3, 2→1, 3→5, 4→6, 5→7, 6→2, 7→4. The write also sets the pending flag.
- R6: A write decoding to 0xC000 issues page 0, odd (bank data) with the data unchanged, but only while the pending flag is set, and it clears the flag. Without the flag it produces no strobe. Writes to other addresses leave the flag unchanged.
- R7: Writes decoding to 0xC001, 0xE000 and 0xE001 issue page 2 odd, page 3 even and page 3 odd respectively, with the data unchanged.
- R8: A write decoding to 0x8000 has no effect: no strobe and no change of `outer_q`.
- R9: An active-low reset clears `outer_q`, the pending flag and both strobes.
- R10: Each strobe is high for exactly one cycle per accepted write, never both at once. Writes below 0x5000, and cycles with `cpu_we` low, produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write valid this cycle |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| core_we | output | 1 | One-cycle command strobe to the banking core |
| core_page | output | 2 | Core register page: 0 bank, 1 mirroring, 2 IRQ counter, 3 IRQ enable |
| core_odd | output | 1 | Odd register within the page |
| out_data | output | 8 | Data for the core command or the work-RAM write |
| wram_we | output | 1 | One-cycle work-RAM write strobe |
| wram_off | output | 13 | Offset within the work-RAM window |
| outer_q | output | 8 | Outer register value |

## Verification
The only hidden state is the pending flag, together with the outer register, which is directly visible. A stuck or stale pending flag shows up at the ports on the next write to a 0xC000 alias: a bank-data strobe appears or goes missing one cycle after that write. The random stream therefore weights bank-select and bank-data aliases heavily and interleaves other registers between them. A wrong permutation or decode shows on the command strobe one cycle after the offending write, so every write is checked in the cycle its result appears and again one cycle later for strobe release.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int ADDR_W = 16;
  localparam int WRAM_W = 13;

  typedef enum logic [3:0] {
    WK_NONE,
    WK_OUTER,
    WK_WRAM,
    WK_MIRROR,
    WK_BSEL,
    WK_BDATA,
    WK_LATCH,
    WK_RELOAD,
    WK_IRQ_OFF,
    WK_IRQ_ON
  } wr_kind_e;

  typedef enum logic [1:0] {
    PG_BANK   = 2'd0,
    PG_MIRROR = 2'd1,
    PG_IRQCNT = 2'd2,
    PG_IRQEN  = 2'd3
  } core_page_e;

  typedef struct packed {
    logic       we;
    core_page_e page;
    logic       odd;
  } core_cmd_t;

endpackage

// File: rtl/scr_addr_decode.sv
module scr_addr_decode
  import scr_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_kind_e          kind_o
);

  localparam logic [3:0] OUTER_NIB = 4'h5;
  localparam logic [2:0] WRAM_TOP  = 3'b011;

  logic [2:0] key;

  always_comb begin
    key = {addr_i[ADDR_W-2:ADDR_W-3], addr_i[0]};
  end

  always_comb begin
    kind_o = WK_NONE;
    if (we_i) begin
      if (addr_i[ADDR_W-1 -: 4] == OUTER_NIB) begin
        kind_o = WK_OUTER;
      end else if (addr_i[ADDR_W-1 -: 3] == WRAM_TOP) begin
        kind_o = WK_WRAM;
      end else if (addr_i[ADDR_W-1]) begin
        unique case (key)
          3'b000:  kind_o = WK_NONE;
          3'b001:  kind_o = WK_MIRROR;
          3'b010:  kind_o = WK_BSEL;
          3'b011:  kind_o = WK_LATCH;
          3'b100:  kind_o = WK_BDATA;
          3'b101:  kind_o = WK_RELOAD;
          3'b110:  kind_o = WK_IRQ_OFF;
          default: kind_o = WK_IRQ_ON;
        endcase
      end
    end
  end

endmodule

// File: rtl/scr_idx_permute.sv
module scr_idx_permute #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] cooked_o
);

  localparam int IDX_W  = 3;
  localparam int KEEP_W = 2;
  localparam int ZERO_W = DATA_W - IDX_W - KEEP_W;

  logic [IDX_W-1:0] idx_new;

  always_comb begin
    unique case (raw_i[IDX_W-1:0])
      3'd0:    idx_new = 3'd0;
      3'd1:    idx_new = 3'd3;
      3'd2:    idx_new = 3'd1;
      3'd3:    idx_new = 3'd5;
      3'd4:    idx_new = 3'd6;
      3'd5:    idx_new = 3'd7;
      3'd6:    idx_new = 3'd2;
      default: idx_new = 3'd4;
    endcase
  end

  always_comb begin
    cooked_o = {raw_i[DATA_W-1 -: KEEP_W], {ZERO_W{1'b0}}, idx_new};
  end

endmodule

// File: rtl/scr_pend_flag.sv
module scr_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_d;

  always_comb begin
    pend_d = pend_o;
    if (set_i) begin
      pend_d = 1'b1;
    end else if (clr_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (set_i || clr_i) begin
      pend_o <= pend_d;
    end
  end

endmodule

// File: rtl/scr_map_frontend.sv
module scr_map_frontend
  import scr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              core_we,
  output logic [1:0]        core_page,
  output logic              core_odd,
  output logic [DATA_W-1:0] out_data,
  output logic              wram_we,
  output logic [12:0]       wram_off,
  output logic [DATA_W-1:0] outer_q
);

  wr_kind_e          kind;
  logic [DATA_W-1:0] bsel_data;
  logic              pend;
  logic              pend_set;
  logic              pend_clr;

  core_cmd_t         cmd_d;
  core_cmd_t         cmd_q;
  logic [DATA_W-1:0] data_d;
  logic              wram_we_d;
  logic              outer_ld;

  scr_addr_decode u_dec (
    .we_i   (cpu_we),
    .addr_i (cpu_addr),
    .kind_o (kind)
  );

  scr_idx_permute #(.DATA_W(DATA_W)) u_perm (
    .raw_i    (cpu_wdata),
    .cooked_o (bsel_data)
  );

  scr_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pend_set),
    .clr_i  (pend_clr),
    .pend_o (pend)
  );

  // next-state
  always_comb begin
    cmd_d     = '{we: 1'b0, page: PG_BANK, odd: 1'b0};
    data_d    = cpu_wdata;
    wram_we_d = 1'b0;
    outer_ld  = 1'b0;
    pend_set  = 1'b0;
    pend_clr  = 1'b0;
    unique case (kind)
      WK_OUTER:   outer_ld  = 1'b1;
      WK_WRAM:    wram_we_d = 1'b1;
      WK_MIRROR:  cmd_d = '{we: 1'b1, page: PG_MIRROR, odd: 1'b0};
      WK_BSEL: begin
        cmd_d    = '{we: 1'b1, page: PG_BANK, odd: 1'b0};
        data_d   = bsel_data;
        pend_set = 1'b1;
      end
      WK_BDATA: begin
        pend_clr = 1'b1;
        if (pend) begin
          cmd_d = '{we: 1'b1, page: PG_BANK, odd: 1'b1};
        end
      end
      WK_LATCH:   cmd_d = '{we: 1'b1, page: PG_IRQCNT, odd: 1'b0};
      WK_RELOAD:  cmd_d = '{we: 1'b1, page: PG_IRQCNT, odd: 1'b1};
      WK_IRQ_OFF: cmd_d = '{we: 1'b1, page: PG_IRQEN,  odd: 1'b0};
      WK_IRQ_ON:  cmd_d = '{we: 1'b1, page: PG_IRQEN,  odd: 1'b1};
      default:    cmd_d = '{we: 1'b0, page: PG_BANK, odd: 1'b0};
    endcase
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '{we: 1'b0, page: PG_BANK, odd: 1'b0};
      wram_we <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      wram_we <= wram_we_d;
    end
  end

  // payload, enabled only when a strobe is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (cmd_d.we || wram_we_d) begin
      out_data <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wram_off <= '0;
    end else if (wram_we_d) begin
      wram_off <= cpu_addr[WRAM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer_q <= '0;
    end else if (outer_ld) begin
      outer_q <= cpu_wdata;
    end
  end

  always_comb begin
    core_we   = cmd_q.we;
    core_page = cmd_q.page;
    core_odd  = cmd_q.odd;
  end

  AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != WK_OUTER) |=> $stable(outer_q)); // R1

  AST_WRAM_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_WRAM) |=> (wram_we && !core_we)); // R2

  AST_BSEL_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_page == 2'd0 && !core_odd) |-> (out_data[5:3] == 3'b000)); // R5

  AST_DATA_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_page == 2'd0 && core_odd) |-> $past(pend)); // R6

  AST_PEND_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_BDATA) |=> !pend); // R6

  AST_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_NONE) |=> (!core_we && !wram_we)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_we && wram_we)); // R10

  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we || wram_we) |-> $past(cpu_we)); // R10

endmodule

// File: tb/tb_scr_map_frontend.sv
`timescale 1ns/1ps
module tb_scr_map_frontend;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        core_we;
  logic [1:0]  core_page;
  logic        core_odd;
  logic [7:0]  out_data;
  logic        wram_we;
  logic [12:0] wram_off;
  logic [7:0]  outer_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  bit         m_pend;
  logic [7:0] m_outer;

  always #2.5 clk = ~clk;

  scr_map_frontend dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .core_we   (core_we),
    .core_page (core_page),
    .core_odd  (core_odd),
    .out_data  (out_data),
    .wram_we   (wram_we),
    .wram_off  (wram_off),
    .outer_q   (outer_q)
  );

  function automatic logic [2:0] idx_map(input logic [2:0] i);
    case (i)
      3'd0: return 3'd0;
      3'd1: return 3'd3;
      3'd2: return 3'd1;
      3'd3: return 3'd5;
      3'd4: return 3'd6;
      3'd5: return 3'd7;
      3'd6: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one write, checked in the cycle its result appears and one cycle later
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bit         e_core = 0;
    bit         e_wram = 0;
    logic [1:0] e_page = 0;
    bit         e_odd  = 0;
    logic [7:0] e_data = d;
    string      req    = "R10";
    if (a[15:12] == 4'h5) begin
      m_outer = d; req = "R1";
    end else if (a[15:13] == 3'b011) begin
      e_wram = 1; req = "R2";
    end else if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: req = "R8";
        3'b001: begin e_core = 1; e_page = 1; req = "R4"; end
        3'b010: begin e_core = 1; e_page = 0;
                      e_data = {d[7:6], 3'b000, idx_map(d[2:0])};
                      m_pend = 1; req = "R5"; end
        3'b011: begin e_core = 1; e_page = 2; req = "R4"; end
        3'b100: begin e_core = m_pend; e_page = 0; e_odd = 1;
                      m_pend = 0; req = "R6"; end
        3'b101: begin e_core = 1; e_page = 2; e_odd = 1; req = "R7"; end
        3'b110: begin e_core = 1; e_page = 3; req = "R7"; end
        default: begin e_core = 1; e_page = 3; e_odd = 1; req = "R7"; end
      endcase
      if (a[12:1] != 0 && a != 16'hA000 && a != 16'hC000) req = {req, "/R3"};
    end
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
    chk(core_we == e_core, req, "core_we", core_we, e_core);
    if (e_core) begin
      chk(core_page == e_page, req, "core_page", core_page, e_page);
      chk(core_odd == e_odd, req, "core_odd", core_odd, e_odd);
      chk(out_data == e_data, req, "core data", out_data, e_data);
    end
    chk(wram_we == e_wram, req, "wram_we", wram_we, e_wram);
    if (e_wram) begin
      chk(wram_off == a[12:0], req, "wram_off", wram_off, a[12:0]);
      chk(out_data == d, req, "wram data", out_data, d);
    end
    chk(outer_q == m_outer, req, "outer_q", outer_q, m_outer);
    @(negedge clk);
    chk(!core_we && !wram_we, "R10", "strobe release", {core_we, wram_we}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_pend = 0; m_outer = 0;
    @(negedge clk);
    chk(outer_q == 8'h00, "R9", "outer after reset", outer_q, 0);
    chk(!core_we && !wram_we, "R9", "strobes in reset", {core_we, wram_we}, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    int          r;
    cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    rst_n = 0; m_pend = 0; m_outer = 0;
    void'($urandom(32'h0114));
    repeat (3) @(negedge clk);
    chk(outer_q == 0 && !core_we && !wram_we, "R9", "reset state",
        {outer_q, core_we, wram_we}, 0);
    rst_n = 1;

    // directed corners
    wr(16'hC000, 8'h11);   // R6: no pending -> ignored
    wr(16'hA000, 8'h04);   // R5: index 4 -> 6
    wr(16'hE000, 8'h00);   // R6: unrelated write keeps flag
    wr(16'hC000, 8'h05);   // R6: accepted
    wr(16'hC000, 8'h07);   // R6: second one ignored
    wr(16'hA000, 8'hFF);   // R5: -> 0xC4
    wr(16'hA000, 8'h39);   // R5: -> 0x03
    wr(16'hDFFE, 8'h2A);   // R3/R6: alias of 0xC000
    wr(16'h5000, 8'h83);   // R1
    wr(16'h5FFF, 8'h5C);   // R1
    wr(16'h6000, 8'h5A);   // R2
    wr(16'h7FFF, 8'hA5);   // R2
    wr(16'h8000, 8'h77);   // R8
    wr(16'h9FFF, 8'h01);   // R3/R4 mirroring alias
    wr(16'hA001, 8'h09);   // R4
    wr(16'hC001, 8'h00);   // R7
    wr(16'hE001, 8'h00);   // R7
    wr(16'h4FFF, 8'hEE);   // R10 below window
    wr(16'h0000, 8'h12);   // R10
    wr(16'hA000, 8'h02);   // R9: flag set, then reset
    do_reset();
    wr(16'hC000, 8'h33);   // R9: flag cleared by reset

    for (int i = 0; i < 1500; i++) begin
      r = $urandom % 12;
      d = 8'($urandom);
      case (r)
        0: a = 16'h5000 | 16'($urandom & 32'h0FFF);
        1: a = 16'h6000 | 16'($urandom & 32'h1FFF);
        2, 3, 4: a = 16'hA000 | 16'($urandom & 32'h1FFE);
        5, 6, 7: a = 16'hC000 | 16'($urandom & 32'h1FFE);
        8: a = 16'($urandom % 32'h5000);
        default: a = 16'h8000 | 16'($urandom & 32'h7FFF);
      endcase
      wr(a, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule